// File: doc/BRIEF.md
# Fetch Next-PC Predictor

This block chooses the address the fetch unit should request in the following cycle. It looks the current fetch address up in a direct-mapped target table whose entries each hold a validity flag, a 30-bit address tag, a stored target and a 2-bit saturating direction counter. A small stack of return addresses handles subroutine returns. The front end supplies the fetch address and a pre-decode class that marks the word as a call, a return or something else. The block then produces a predicted next address and a flag that says whether it predicted a redirect.

A resolve port is driven by the execute stage. It carries the branch address, the real direction and target, and the direction and target that were predicted for that branch, which travel down the pipe with it. The resolve port trains the table and raises a mispredict flag in the same cycle. Acting on that flag, for example by flushing the pipe, is left to the surrounding core. Returns never use the table's target: they take the popped stack value.

Top module: `nxtpc_predictor`

## Requirements
- R1: After reset every table entry is invalid and the stack is empty. Any lookup then predicts fetch_pc + 4 with pred_taken low.
- R2: The table index is fetch_pc[IDX_W+1:2], and the tag compared is fetch_pc[31:2]. A second address that shares the index but differs in the tag does not hit, so it predicts fetch_pc + 4.
- R3: For a fetch whose class is not return, the prediction is the stored target with pred_taken high only when the entry hits and the counter's upper bit is 1. In every other case it is fetch_pc + 4 with pred_taken low.
- R4: A resolved taken branch that misses the table allocates its entry. The entry gets its tag and target and a counter value of weakly taken (2'b10), so a single not-taken resolve then turns the prediction to not taken.
- R5: A resolved not-taken branch that misses the table leaves the table unchanged.
- R6: The counter saturates at 2'b00 and 2'b11, with encodings 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. Starting from a strong state, the predicted direction flips only after two opposite resolves in a row.
- R7: A resolved taken branch that hits the table overwrites the stored target with the resolved target.
- R8: A valid fetch of class call (2'b01) pushes fetch_pc + 4. A fetch of class return (2'b10) with a non-empty stack predicts the top entry with pred_taken high, whatever the table holds, and a valid return fetch pops that entry.
- R9: The stack is last-in first-out, so nested calls return in reverse order.
- R10: The stack holds 8 entries. A push onto a full stack overwrites the oldest entry. A return fetched while the stack is empty predicts fetch_pc + 4 with pred_taken low.
- R11: res_mispredict is high in a cycle with res_valid high when the resolved direction differs from the predicted direction, or when both are taken and the targets differ. It is low otherwise.
- R12: Table updates made by a resolve take effect from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch slot is real; enables stack push and pop |
| fetch_pc | input | 32 | Current fetch address |
| fetch_cls | input | 2 | Pre-decode class: 00 other, 01 call, 10 return |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Prediction is a redirect |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | 32 | Actual target |
| res_pred_taken | input | 1 | Direction that was predicted for it |
| res_pred_target | input | 32 | Target that was predicted for it |
| res_mispredict | output | 1 | Prediction was wrong |

## Verification
The assertions check the stack bookkeeping on every cycle: its depth stays within bounds, moves by one on each push or pop, and a return with a non-empty stack always redirects. They also check that a redirect outside a return needs a table hit, and that the mispredict flag follows the resolve inputs. What only the scenarios can show is the contents: which target is returned after allocation, aliasing or retargeting, and the counter's hysteresis over a sequence of resolves. The same holds for the stack's last-in first-out order and its wrap-around after nine calls.

// File: rtl/nxtpc_pkg.sv
// Shared types and helpers for the next-PC predictor.
// Assumes 4-byte aligned instructions.
package nxtpc_pkg;

    typedef enum logic [1:0] {
        CLS_OTHER = 2'b00,
        CLS_CALL  = 2'b01,
        CLS_RET   = 2'b10
    } fetch_cls_e;

    // Two-bit saturating direction counter step
    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic tk);
        logic [1:0] r;
        if (tk) r = (c == 2'b11) ? c : c + 2'b01;
        else    r = (c == 2'b00) ? c : c - 2'b01;
        return r;
    endfunction

endpackage

// File: rtl/nxtpc_btb.sv
// Direct-mapped target table with a 2-bit direction counter per entry.
// The lookup is combinational on the current state. An update from the
// resolve port becomes visible after the next clock edge. The tag is the
// whole word address, so aliasing never causes a false hit.
module nxtpc_btb #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - 2;

    logic              ent_vld [DEPTH];
    logic [TAG_W-1:0]  ent_tag [DEPTH];
    logic [ADDR_W-1:0] ent_tgt [DEPTH];
    logic [1:0]        ent_ctr [DEPTH];

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic             up_hit;

    assign lk_idx = lk_pc[IDX_W+1:2];
    assign up_idx = up_pc[IDX_W+1:2];

    // Lookup: hit test, direction and stored target
    always_comb begin
        lk_hit    = ent_vld[lk_idx] && (ent_tag[lk_idx] == lk_pc[ADDR_W-1:2]);
        lk_taken  = lk_hit && ent_ctr[lk_idx][1];
        lk_target = ent_tgt[lk_idx];
    end

    // Update-side hit test
    assign up_hit = ent_vld[up_idx] && (ent_tag[up_idx] == up_pc[ADDR_W-1:2]);

    // Valid bits and counters: reset, train on hit, allocate on taken miss
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ent_vld[i] <= 1'b0;
                ent_ctr[i] <= 2'b00;
            end
        end else if (up_valid) begin
            if (up_hit) begin
                ent_ctr[up_idx] <= nxtpc_pkg::ctr_step(ent_ctr[up_idx], up_taken);
            end else if (up_taken) begin
                ent_vld[up_idx] <= 1'b1;
                ent_ctr[up_idx] <= 2'b10;
            end
        end
    end

    // Tag and target storage: written on allocate or on a taken hit
    always_ff @(posedge clk) begin
        if (up_valid && up_taken) begin
            ent_tag[up_idx] <= up_pc[ADDR_W-1:2];
            ent_tgt[up_idx] <= up_target;
        end
    end

endmodule

// File: rtl/nxtpc_ras.sv
// Circular return address stack. DEPTH must be a power of two.
// A push onto a full stack overwrites the oldest entry. A pop from an
// empty stack does nothing. Push and pop never occur in the same cycle.
module nxtpc_ras #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [ADDR_W-1:0]          push_addr,
    input  logic                       pop,
    output logic [ADDR_W-1:0]          top_addr,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] depth_cnt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] stk [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [CNT_W-1:0]  cnt;

    assign top_addr  = stk[wr_ptr - 1'b1];
    assign empty     = (cnt == '0);
    assign depth_cnt = cnt;

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            cnt    <= '0;
        end else if (push) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
        end else if (pop && !empty) begin
            wr_ptr <= wr_ptr - 1'b1;
            cnt    <= cnt - 1'b1;
        end
    end

    // Entry storage written on push
    always_ff @(posedge clk) begin
        if (push) stk[wr_ptr] <= push_addr;
    end

endmodule

// File: rtl/nxtpc_predictor.sv
// Fetch next-PC predictor. It merges the target table lookup, the
// counter direction and the return stack into one next-address mux.
// A return with a non-empty stack bypasses the table. The resolve port
// trains the table and flags mispredicts; flushing is done elsewhere.
module nxtpc_predictor #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 4,
    parameter int RAS_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [1:0]        fetch_cls,
    output logic [ADDR_W-1:0] pred_next_pc,
    output logic              pred_taken,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              res_pred_taken,
    input  logic [ADDR_W-1:0] res_pred_target,
    output logic              res_mispredict
);
    import nxtpc_pkg::*;

    localparam int CNT_W = $clog2(RAS_DEPTH + 1);

    logic              btb_hit, btb_taken;
    logic [ADDR_W-1:0] btb_target;
    logic [ADDR_W-1:0] seq_pc, ras_top;
    logic              ras_empty, is_call, is_ret;
    logic [CNT_W-1:0]  ras_cnt;

    assign seq_pc  = fetch_pc + ADDR_W'(4);
    assign is_call = (fetch_cls == CLS_CALL);
    assign is_ret  = (fetch_cls == CLS_RET);

    nxtpc_btb #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (fetch_pc),
        .lk_hit    (btb_hit),
        .lk_taken  (btb_taken),
        .lk_target (btb_target),
        .up_valid  (res_valid),
        .up_pc     (res_pc),
        .up_taken  (res_taken),
        .up_target (res_target)
    );

    nxtpc_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fetch_valid && is_call),
        .push_addr (seq_pc),
        .pop       (fetch_valid && is_ret),
        .top_addr  (ras_top),
        .empty     (ras_empty),
        .depth_cnt (ras_cnt)
    );

    // Next-address mux: stack for returns, else table when predicted taken
    always_comb begin
        pred_next_pc = seq_pc;
        pred_taken   = 1'b0;
        if (is_ret) begin
            if (!ras_empty) begin
                pred_next_pc = ras_top;
                pred_taken   = 1'b1;
            end
        end else if (btb_taken) begin
            pred_next_pc = btb_target;
            pred_taken   = 1'b1;
        end
    end

    // Mispredict report from resolved versus carried prediction
    always_comb begin
        res_mispredict = 1'b0;
        if (res_valid) begin
            if (res_taken != res_pred_taken)
                res_mispredict = 1'b1;
            else if (res_taken && (res_target != res_pred_target))
                res_mispredict = 1'b1;
        end
    end

endmodule

// File: rtl/nxtpc_predictor_chk.sv
// Property checker for nxtpc_predictor, attached with bind.
// It watches the ports plus the table hit and stack depth wires.
module nxtpc_predictor_chk #(
    parameter int ADDR_W    = 32,
    parameter int RAS_DEPTH = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           fetch_valid,
    input logic [1:0]                     fetch_cls,
    input logic                           pred_taken,
    input logic                           btb_hit,
    input logic [$clog2(RAS_DEPTH+1)-1:0] ras_cnt,
    input logic                           res_valid,
    input logic                           res_taken,
    input logic                           res_pred_taken,
    input logic                           res_mispredict
);
    localparam int CNT_W = $clog2(RAS_DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(RAS_DEPTH);

    // R10: depth never exceeds capacity
    a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ras_cnt <= CNT_FULL);

    // R8: a call on a non-full stack grows it by one
    a_r8_push_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_cls == nxtpc_pkg::CLS_CALL && ras_cnt != CNT_FULL)
        |=> ras_cnt == $past(ras_cnt) + 1'b1);

    // R8: a return on a non-empty stack shrinks it by one
    a_r8_pop_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_cls == nxtpc_pkg::CLS_RET && ras_cnt != '0)
        |=> ras_cnt == $past(ras_cnt) - 1'b1);

    // R8: a return with stacked entries always redirects
    a_r8_ret_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_cls == nxtpc_pkg::CLS_RET && ras_cnt != '0) |-> pred_taken);

    // R3: outside returns, a redirect requires a table hit
    a_r3_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_cls != nxtpc_pkg::CLS_RET && pred_taken) |-> btb_hit);

    // R11: no mispredict without a resolve, always one on direction mismatch
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> !res_mispredict);
    a_r11_dir_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken != res_pred_taken) |-> res_mispredict);

endmodule

bind nxtpc_predictor nxtpc_predictor_chk #(
    .ADDR_W    (ADDR_W),
    .RAS_DEPTH (RAS_DEPTH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_valid    (fetch_valid),
    .fetch_cls      (fetch_cls),
    .pred_taken     (pred_taken),
    .btb_hit        (btb_hit),
    .ras_cnt        (ras_cnt),
    .res_valid      (res_valid),
    .res_taken      (res_taken),
    .res_pred_taken (res_pred_taken),
    .res_mispredict (res_mispredict)
);

// File: tb/nxtpc_predictor_test.sv
`timescale 1ns/1ps
// Directed bench for nxtpc_predictor: one task per scenario.
module nxtpc_predictor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic [1:0]  fetch_cls = 2'b00;
    logic [31:0] pred_next_pc;
    logic        pred_taken;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;
    logic        res_pred_taken = 1'b0;
    logic [31:0] res_pred_target = '0;
    logic        res_mispredict;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [1:0] K_OTH = 2'b00, K_CALL = 2'b01, K_RET = 2'b10;

    always #2.5 clk = ~clk;

    nxtpc_predictor uut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_cls(fetch_cls), .pred_next_pc(pred_next_pc), .pred_taken(pred_taken),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_target(res_target), .res_pred_taken(res_pred_taken),
        .res_pred_target(res_pred_target), .res_mispredict(res_mispredict)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive a fetch, check the prediction, then let one edge pass
    task automatic fetch(input logic v, input logic [31:0] pc, input logic [1:0] cls,
                         input logic [31:0] exp_pc, input logic exp_tk, input string req);
        @(negedge clk);
        fetch_valid = v; fetch_pc = pc; fetch_cls = cls;
        #1;
        chk(req, pred_next_pc, exp_pc);
        chk(req, {31'b0, pred_taken}, {31'b0, exp_tk});
        @(posedge clk); #1;
        fetch_valid = 1'b0;
    endtask

    // Drive one resolve, check the mispredict flag, then let one edge pass
    task automatic resolve(input logic [31:0] pc, input logic tk, input logic [31:0] tgt,
                           input logic ptk, input logic [31:0] ptgt, input logic exp_mp,
                           input string req);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt;
        res_pred_taken = ptk; res_pred_target = ptgt;
        #1;
        chk(req, {31'b0, res_mispredict}, {31'b0, exp_mp});
        @(posedge clk); #1;
        res_valid = 1'b0;
    endtask

    task automatic t_reset();
        fetch(1'b0, 32'h100, K_OTH, 32'h104, 1'b0, "R1 empty table");
        fetch(1'b1, 32'h200, K_RET, 32'h204, 1'b0, "R1 R10 empty stack return");
    endtask

    task automatic t_alloc();
        resolve(32'h1000, 1'b1, 32'h2000, 1'b0, 32'h0, 1'b1, "R11 direction miss");
        fetch(1'b0, 32'h1000, K_OTH, 32'h2000, 1'b1, "R4 R3 R12 allocated weak taken");
        fetch(1'b0, 32'h1040, K_OTH, 32'h1044, 1'b0, "R2 alias tag mismatch");
    endtask

    task automatic t_no_alloc();
        resolve(32'h3000, 1'b0, 32'h5000, 1'b0, 32'h0, 1'b0, "R11 correct not taken");
        fetch(1'b0, 32'h3000, K_OTH, 32'h3004, 1'b0, "R5 no allocate");
    endtask

    task automatic t_counter();
        resolve(32'h1000, 1'b0, 32'h0, 1'b1, 32'h2000, 1'b1, "R11 taken predicted, fell through");
        fetch(1'b0, 32'h1000, K_OTH, 32'h1004, 1'b0, "R4 weak taken drops on one");
        resolve(32'h1000, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, "R6 to strong not taken");
        resolve(32'h1000, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, "R6 saturate low");
        resolve(32'h1000, 1'b1, 32'h2000, 1'b0, 32'h0, 1'b1, "R6 first taken");
        fetch(1'b0, 32'h1000, K_OTH, 32'h1004, 1'b0, "R6 strong nt holds after one");
        resolve(32'h1000, 1'b1, 32'h2000, 1'b0, 32'h0, 1'b1, "R6 second taken");
        fetch(1'b0, 32'h1000, K_OTH, 32'h2000, 1'b1, "R6 flips after two");
        resolve(32'h1000, 1'b1, 32'h2000, 1'b1, 32'h2000, 1'b0, "R6 to strong taken");
        resolve(32'h1000, 1'b1, 32'h2000, 1'b1, 32'h2000, 1'b0, "R6 saturate high");
        resolve(32'h1000, 1'b0, 32'h0, 1'b1, 32'h2000, 1'b1, "R6 first not taken");
        fetch(1'b0, 32'h1000, K_OTH, 32'h2000, 1'b1, "R6 strong taken holds after one");
        resolve(32'h1000, 1'b0, 32'h0, 1'b1, 32'h2000, 1'b1, "R6 second not taken");
        fetch(1'b0, 32'h1000, K_OTH, 32'h1004, 1'b0, "R6 flips to not taken");
    endtask

    task automatic t_target();
        resolve(32'h1000, 1'b1, 32'h2400, 1'b1, 32'h2000, 1'b1, "R11 target differs");
        fetch(1'b0, 32'h1000, K_OTH, 32'h2400, 1'b1, "R7 retarget on hit");
        resolve(32'h1000, 1'b1, 32'h2400, 1'b1, 32'h2400, 1'b0, "R11 exact match");
    endtask

    task automatic t_ras();
        fetch(1'b1, 32'h500, K_CALL, 32'h504, 1'b0, "R8 call other path");
        fetch(1'b1, 32'h600, K_CALL, 32'h604, 1'b0, "R8 second call");
        fetch(1'b1, 32'h900, K_RET, 32'h604, 1'b1, "R9 inner return");
        fetch(1'b1, 32'h900, K_RET, 32'h504, 1'b1, "R9 outer return");
        fetch(1'b1, 32'h900, K_RET, 32'h904, 1'b0, "R10 drained stack");
        resolve(32'h700, 1'b1, 32'h9000, 1'b0, 32'h0, 1'b1, "R11 allocate for bypass");
        fetch(1'b0, 32'h700, K_OTH, 32'h9000, 1'b1, "R3 entry present");
        fetch(1'b1, 32'h800, K_CALL, 32'h804, 1'b0, "R8 push for bypass");
        fetch(1'b1, 32'h700, K_RET, 32'h804, 1'b1, "R8 return bypasses table");
    endtask

    task automatic t_wrap();
        for (int k = 1; k <= 9; k++)
            fetch(1'b1, 32'h4000 + 32'(k * 16), K_CALL, 32'h4004 + 32'(k * 16), 1'b0, "R10 fill");
        for (int k = 9; k >= 2; k--)
            fetch(1'b1, 32'hA00, K_RET, 32'h4004 + 32'(k * 16), 1'b1, "R10 wrap order");
        fetch(1'b1, 32'hA00, K_RET, 32'hA04, 1'b0, "R10 oldest overwritten");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_alloc();
        t_no_alloc();
        t_counter();
        t_target();
        t_ras();
        t_wrap();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule